// File: doc/BRIEF.md
# Unaligned Access Fragment Splitter

This block sits between a processor load/store port and a physical bus organised in 32-bit longwords. It takes one request, which may be unaligned: a byte address, a size (byte, word or longword), a direction and write data. Along with it comes a second physical address that an external translation stage supplies for the following page. The block turns the request into one or two fragment transactions. Each fragment names a longword-aligned address, a starting byte offset inside that longword and a byte count, and each touches only the bytes the access needs. A fragment never reads or writes a neighbouring byte, so targets with read side effects or byte-granular writes see exactly the intended traffic.

When an access runs past the end of its longword, the first fragment covers the bytes that remain in that longword. The second fragment starts at byte 0 of the next longword. If the first longword is the last one in its page, the second longword comes from the translated address and may sit anywhere in physical space. Each fragment finishes with a response. For reads the response data is right-aligned, and the block joins the two pieces into one right-aligned result. A one-cycle done pulse marks the end of the whole request.

Top module: `unaligned_splitter`

## Requirements
- R1: `req_ready_o` is high only while the block is idle. It goes low in the cycle after a request is accepted and stays low until the last fragment's response has been taken.
- R2: Size encoding: 0 is a byte, 1 is a word (2 bytes), 2 is a longword (4 bytes), and 3 is treated as a longword. With bo = address bits [1:0], a request where bo plus the size is at most 4 is issued as one fragment. That fragment has offset bo and a count equal to the size.
- R3: A longword at bo 1, 2 or 3 is issued as a low fragment of 4-bo bytes at offset bo, followed by a high fragment of bo bytes at offset 0. The low fragment is always issued first.
- R4: A word at bo 1 is a single 2-byte fragment at offset 1. A word at bo 3 is two 1-byte fragments: offset 3, then offset 0 of the next longword.
- R5: When the first longword is not the last longword of its page (address bits [PAGE_BITS-1:2] not all ones), the high fragment address is the request address with bits [1:0] cleared, plus 4. The second address input has no effect in this case.
- R6: When the first longword is the last of its page, the high fragment address is the second address input with bits [1:0] cleared.
- R7: Write fragment data is right-aligned. The low fragment carries the write data masked to its count. The high fragment carries the write data shifted right by 8 times the low count, masked to its own count. No data bits lie above a fragment's count.
- R8: The block masks each response to its fragment's count before use. The read result is low | (high << 8*low_count), giving the requested bytes right-aligned with zeros above.
- R9: While `frag_valid_o` is high and `frag_ready_i` is low, all fragment outputs hold. The fragment address always has bits [1:0] at zero, and offset plus count never exceeds 4.
- R10: `done_o` pulses for exactly one cycle, in the cycle after the last fragment's response is taken. `rdata_o` holds the read result from that cycle until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_addr_i | input | AW | Byte address of the access |
| req_size_i | input | 2 | 0 byte, 1 word, 2/3 longword |
| req_write_i | input | 1 | 1 for a write |
| req_wdata_i | input | 32 | Right-aligned write data |
| req_addr2_i | input | AW | Translated address of the next page |
| frag_valid_o | output | 1 | Fragment present |
| frag_ready_i | input | 1 | Bus takes the fragment |
| frag_addr_o | output | AW | Longword-aligned fragment address |
| frag_offset_o | output | 2 | First byte inside the longword |
| frag_count_o | output | 3 | Number of bytes, 1 to 4 |
| frag_write_o | output | 1 | Fragment direction |
| frag_wdata_o | output | 32 | Right-aligned, masked write data |
| rsp_valid_i | input | 1 | Fragment response |
| rsp_rdata_i | input | 32 | Right-aligned read data of the fragment |
| done_o | output | 1 | One-cycle end of request |
| rdata_o | output | 32 | Merged read result |

## Verification
The assertions assume that the bus returns exactly one response for each accepted fragment, and only after that fragment's handshake. They also assume the requester does not change its request fields while it waits. The bench's responder answers one cycle after each fragment handshake, never earlier and never twice. Its fill bytes above the count test the masking rule, and a periodic ready stall exercises the hold rule without breaking the one-response pairing. The driver holds each request stable until the block accepts it and issues the next request only after the done pulse.

// File: rtl/splitter_pkg.sv
package splitter_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef struct packed {
    logic [1:0]    off;
    logic [2:0]    cnt;
    logic [DW-1:0] data;
  } frag_t;

  function automatic logic [DW-1:0] cnt_mask(input logic [2:0] cnt);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < 4; i++)
      if (3'(i) < cnt) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [2:0] size_bytes(input size_e s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_WORD: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/splitter_plan.sv
module splitter_plan
  import splitter_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned PAGE_BITS = 9
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] addr2_i,
  input  size_e         size_i,
  input  logic [DW-1:0] wdata_i,
  output logic          split_o,
  output logic [AW-1:0] lo_base_o,
  output logic [AW-1:0] hi_base_o,
  output frag_t         lo_o,
  output frag_t         hi_o
);
  localparam int unsigned LWB = AW - 2;

  logic [1:0] bo;
  logic [2:0] nbytes, lo_cnt, hi_cnt;
  logic [3:0] span;
  logic       page_end;
  logic [AW-1:0] next_lw, xlat_lw;

  assign bo       = addr_i[1:0];
  assign nbytes   = size_bytes(size_i);
  assign span     = {2'b00, bo} + {1'b0, nbytes};
  assign split_o  = span > 4'd4;
  assign lo_cnt   = split_o ? (3'd4 - {1'b0, bo}) : nbytes;
  assign hi_cnt   = split_o ? (nbytes - lo_cnt) : 3'd0;
  // last longword of the page: the next one must come from translation
  assign page_end = &addr_i[PAGE_BITS-1:2];
  assign next_lw  = {addr_i[AW-1:2] + LWB'(1), 2'b00};
  assign xlat_lw  = addr2_i & ~AW'(3);

  assign lo_base_o = {addr_i[AW-1:2], 2'b00};
  assign hi_base_o = page_end ? xlat_lw : next_lw;

  always_comb begin
    lo_o.off  = bo;
    lo_o.cnt  = lo_cnt;
    lo_o.data = wdata_i & cnt_mask(lo_cnt);
    hi_o.off  = 2'd0;
    hi_o.cnt  = hi_cnt;
    hi_o.data = (wdata_i >> {lo_cnt, 3'b000}) & cnt_mask(hi_cnt);
  end
endmodule

// File: rtl/splitter_merge.sv
module splitter_merge
  import splitter_pkg::*;
(
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  input  logic [2:0]    lo_cnt_i,
  input  logic [2:0]    hi_cnt_i,
  output logic [DW-1:0] word_o
);
  logic [DW-1:0] lo_m, hi_m;
  assign lo_m   = lo_i & cnt_mask(lo_cnt_i);
  assign hi_m   = hi_i & cnt_mask(hi_cnt_i);
  assign word_o = lo_m | (hi_m << {lo_cnt_i, 3'b000});
endmodule

// File: rtl/unaligned_splitter.sv
module unaligned_splitter
  import splitter_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned PAGE_BITS = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [1:0]    req_size_i,
  input  logic          req_write_i,
  input  logic [31:0]   req_wdata_i,
  input  logic [AW-1:0] req_addr2_i,
  output logic          frag_valid_o,
  input  logic          frag_ready_i,
  output logic [AW-1:0] frag_addr_o,
  output logic [1:0]    frag_offset_o,
  output logic [2:0]    frag_count_o,
  output logic          frag_write_o,
  output logic [31:0]   frag_wdata_o,
  input  logic          rsp_valid_i,
  input  logic [31:0]   rsp_rdata_i,
  output logic          done_o,
  output logic [31:0]   rdata_o
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_LO, ST_LO_WAIT, ST_HI, ST_HI_WAIT
  } state_e;

  state_e        state_q;
  logic          split_d, split_q, write_q, done_q;
  logic [AW-1:0] lo_base_d, hi_base_d, lo_base_q, hi_base_q;
  frag_t         lo_d, hi_d, lo_q, hi_q;
  logic [DW-1:0] lo_rdata_q, rdata_q, merged;
  logic [DW-1:0] m_lo;
  logic [2:0]    m_hi_cnt;
  logic          sel_hi;

  splitter_plan #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_plan (
    .addr_i   (req_addr_i),
    .addr2_i  (req_addr2_i),
    .size_i   (size_e'(req_size_i)),
    .wdata_i  (req_wdata_i),
    .split_o  (split_d),
    .lo_base_o(lo_base_d),
    .hi_base_o(hi_base_d),
    .lo_o     (lo_d),
    .hi_o     (hi_d)
  );

  // unsplit request completes from the live response
  assign m_lo     = (state_q == ST_LO_WAIT) ? rsp_rdata_i : lo_rdata_q;
  assign m_hi_cnt = (state_q == ST_HI_WAIT) ? hi_q.cnt : 3'd0;

  splitter_merge u_merge (
    .lo_i    (m_lo),
    .hi_i    (rsp_rdata_i),
    .lo_cnt_i(lo_q.cnt),
    .hi_cnt_i(m_hi_cnt),
    .word_o  (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      split_q    <= 1'b0;
      write_q    <= 1'b0;
      done_q     <= 1'b0;
      lo_base_q  <= '0;
      hi_base_q  <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
      lo_rdata_q <= '0;
      rdata_q    <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          split_q   <= split_d;
          write_q   <= req_write_i;
          lo_base_q <= lo_base_d;
          hi_base_q <= hi_base_d;
          lo_q      <= lo_d;
          hi_q      <= hi_d;
          state_q   <= ST_LO;
        end
        ST_LO: if (frag_ready_i) state_q <= ST_LO_WAIT;
        ST_LO_WAIT: if (rsp_valid_i) begin
          lo_rdata_q <= rsp_rdata_i;
          if (split_q) state_q <= ST_HI;
          else begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            rdata_q <= merged;
          end
        end
        ST_HI: if (frag_ready_i) state_q <= ST_HI_WAIT;
        ST_HI_WAIT: if (rsp_valid_i) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          rdata_q <= merged;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sel_hi        = (state_q == ST_HI) || (state_q == ST_HI_WAIT);
  assign req_ready_o   = (state_q == ST_IDLE);
  assign frag_valid_o  = (state_q == ST_LO) || (state_q == ST_HI);
  assign frag_addr_o   = sel_hi ? hi_base_q : lo_base_q;
  assign frag_offset_o = sel_hi ? hi_q.off  : lo_q.off;
  assign frag_count_o  = sel_hi ? hi_q.cnt  : lo_q.cnt;
  assign frag_wdata_o  = sel_hi ? hi_q.data : lo_q.data;
  assign frag_write_o  = write_q;
  assign done_o        = done_q;
  assign rdata_o       = rdata_q;
endmodule

// File: rtl/splitter_chk.sv
module splitter_chk
  import splitter_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          frag_valid_o,
  input logic          frag_ready_i,
  input logic [AW-1:0] frag_addr_o,
  input logic [1:0]    frag_offset_o,
  input logic [2:0]    frag_count_o,
  input logic [31:0]   frag_wdata_o,
  input logic          done_o
);
  // R1
  ready_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frag_valid_o |-> !req_ready_o);

  // R1
  accept_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  // R9
  frag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frag_valid_o && !frag_ready_i) |=> (frag_valid_o && $stable(frag_addr_o)
      && $stable(frag_offset_o) && $stable(frag_count_o) && $stable(frag_wdata_o)));

  // R9
  frag_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frag_valid_o |-> (frag_addr_o[1:0] == 2'b00 && frag_count_o != 3'd0
      && ({2'b00, frag_offset_o} + {1'b0, frag_count_o}) <= 4'd4));

  // R7
  wdata_fit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frag_valid_o |-> ((frag_wdata_o & ~cnt_mask(frag_count_o)) == '0));

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind unaligned_splitter splitter_chk #(.AW(AW)) u_splitter_chk (.*);

// File: tb/unaligned_splitter_tb.sv
module unaligned_splitter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic [AW-1:0] req_addr_i = '0;
  logic [1:0]    req_size_i = '0;
  logic          req_write_i = 1'b0;
  logic [31:0]   req_wdata_i = '0;
  logic [AW-1:0] req_addr2_i = '0;
  logic          frag_valid_o;
  logic          frag_ready_i = 1'b0;
  logic [AW-1:0] frag_addr_o;
  logic [1:0]    frag_offset_o;
  logic [2:0]    frag_count_o;
  logic          frag_write_o;
  logic [31:0]   frag_wdata_o;
  logic          rsp_valid_i = 1'b0;
  logic [31:0]   rsp_rdata_i = '0;
  logic          done_o;
  logic [31:0]   rdata_o;

  unaligned_splitter #(.AW(AW), .PAGE_BITS(9)) dut_i (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, failures = 0, done_cnt = 0, cyc = 0;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [1:0]    off;
    logic [2:0]    cnt;
    logic          wr;
    logic [31:0]   data;
  } exp_frag_t;

  exp_frag_t   frag_q[$];
  string       frag_tag_q[$];
  logic [32:0] res_q[$];

  function automatic logic [7:0] mb(input logic [AW-1:0] a);
    return (a[7:0] * 8'd13 + a[15:8]) ^ 8'h3C;
  endfunction

  function automatic logic [31:0] msk(input int n);
    logic [31:0] m = '0;
    for (int i = 0; i < n; i++) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model built from the requirements
  task automatic do_req(input logic [AW-1:0] a, input int sz, input bit wr,
                        input logic [31:0] wd, input logic [AW-1:0] a2, input string tag);
    int nb, bo, lo, hi, target;
    logic [AW-1:0] lw, hb;
    logic [31:0] res;
    exp_frag_t f;
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    bo = int'(a[1:0]);
    lw = a & ~AW'(3);
    res = '0;
    if (bo + nb <= 4) begin
      lo = nb; hi = 0; hb = '0;
    end else begin
      lo = 4 - bo; hi = nb - lo;
      hb = (a[8:2] == 7'h7F) ? (a2 & ~AW'(3)) : lw + AW'(4);
    end
    f = '{addr: lw, off: 2'(bo), cnt: 3'(lo), wr: wr, data: wd & msk(lo)};
    frag_q.push_back(f); frag_tag_q.push_back(tag);
    for (int i = 0; i < lo; i++) res[8*i +: 8] = mb(lw + AW'(bo + i));
    if (hi > 0) begin
      f = '{addr: hb, off: 2'd0, cnt: 3'(hi), wr: wr, data: (wd >> (8*lo)) & msk(hi)};
      frag_q.push_back(f); frag_tag_q.push_back(tag);
      for (int j = 0; j < hi; j++) res[8*(lo+j) +: 8] = mb(hb + AW'(j));
    end
    res_q.push_back({!wr, res});
    target = done_cnt + 1;
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a; req_size_i = 2'(sz);
    req_write_i = wr; req_wdata_i = wd; req_addr2_i = a2;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(req_ready_o == 1'b0, "R1 ready low after accept", 64'(req_ready_o), 64'd0);
    while (done_cnt < target) @(negedge clk_i);
  endtask

  // monitor and bus responder
  bit          rsp_pend = 0;
  logic [31:0] rsp_data = '0;
  initial begin
    forever begin
      @(negedge clk_i);
      cyc++;
      rsp_valid_i = rsp_pend;
      rsp_rdata_i = rsp_pend ? rsp_data : 32'hDEAD_BEEF;
      rsp_pend = 0;
      frag_ready_i = (cyc % 3 != 1);
      if (rst_ni && frag_valid_o && frag_ready_i) begin
        exp_frag_t e;
        string t;
        if (frag_q.size() == 0) begin
          chk(0, "R2 unexpected fragment", 64'(frag_addr_o), 64'd0);
        end else begin
          e = frag_q.pop_front(); t = frag_tag_q.pop_front();
          chk(frag_addr_o == e.addr, {t, " addr"}, 64'(frag_addr_o), 64'(e.addr));
          chk(frag_offset_o == e.off && frag_count_o == e.cnt, {t, " off/cnt"},
              64'({frag_offset_o, frag_count_o}), 64'({e.off, e.cnt}));
          chk(frag_write_o == e.wr && (!e.wr || frag_wdata_o == e.data), {t, " wdata"},
              64'(frag_wdata_o), 64'(e.data));
        end
        rsp_data = 32'hEEEE_EEEE;  // filler above count must be dropped (R8)
        for (int i = 0; i < int'(frag_count_o); i++)
          rsp_data[8*i +: 8] = mb(frag_addr_o + AW'(frag_offset_o) + AW'(i));
        rsp_pend = 1;
      end
      if (rst_ni && done_o) begin
        logic [32:0] r;
        chk(frag_q.size() == 0, "R10 done before last fragment", 64'(frag_q.size()), 64'd0);
        if (res_q.size() == 0) chk(0, "R10 unexpected done", 64'd1, 64'd0);
        else begin
          r = res_q.pop_front();
          if (r[32]) chk(rdata_o == r[31:0], "R8 read result", 64'(rdata_o), 64'(r[31:0]));
        end
        done_cnt++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    chk(0, "watchdog expired", 64'(cyc), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(req_ready_o == 1'b1 && frag_valid_o == 1'b0, "R1 reset idle",
        64'({req_ready_o, frag_valid_o}), 64'b10);
    chk(done_o == 1'b0, "R10 reset no done", 64'(done_o), 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    // R2 single fragments
    for (int b = 0; b < 4; b++) do_req(32'h0000_1200 + b, 0, 0, 0, 0, "R2 byte");
    do_req(32'h0000_1240, 1, 0, 0, 0, "R2 word bo0");
    do_req(32'h0000_1242, 1, 0, 0, 0, "R2 word bo2");
    do_req(32'h0000_1250, 2, 0, 0, 0, "R2 long bo0");
    do_req(32'h0000_1254, 3, 0, 0, 0, "R2 size3 as long");
    // R4
    do_req(32'h0000_1261, 1, 0, 0, 0, "R4 word bo1");
    do_req(32'h0000_1263, 1, 0, 0, 0, "R4 word bo3");
    // R3 and R5 (second address ignored when not at page end)
    do_req(32'h0000_1271, 2, 0, 0, 32'hABCD_0000, "R3 long bo1");
    do_req(32'h0000_1272, 2, 0, 0, 32'h5555_5555, "R3 long bo2");
    do_req(32'h0000_1273, 2, 0, 0, 32'h7777_7777, "R5 long bo3 no cross");
    // R6 page crossing
    do_req(32'h0000_13FD, 2, 0, 0, 32'h0004_5A17, "R6 long cross");
    do_req(32'h0000_15FF, 1, 0, 0, 32'h0008_8002, "R6 word cross");
    // R7 writes
    do_req(32'h0000_2001, 2, 1, 32'hA1B2_C3D4, 0, "R7 long bo1 write");
    do_req(32'h0000_2002, 2, 1, 32'h1122_3344, 0, "R7 long bo2 write");
    do_req(32'h0000_2003, 2, 1, 32'hCAFE_F00D, 0, "R7 long bo3 write");
    do_req(32'h0000_2013, 1, 1, 32'hFFFF_9876, 0, "R7 word bo3 write");
    do_req(32'h0000_2021, 1, 1, 32'h0000_4321, 0, "R7 word bo1 write");
    do_req(32'h0000_2032, 0, 1, 32'hFFFF_FF5C, 0, "R7 byte write");
    do_req(32'h0000_21FE, 2, 1, 32'h8765_4321, 32'h0030_0101, "R7 R6 cross write");
    repeat (4) @(negedge clk_i);
    chk(frag_q.size() == 0 && res_q.size() == 0, "R10 all items drained",
        64'(frag_q.size() + res_q.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule